// File: doc/BRIEF.md
# Byte Stream to Word Packer and Word to Byte Unpacker

This block sits between a byte-oriented data path and a serial engine whose native unit is a 32-bit word. A single byte count, loaded while the block is idle, sets the length of a transfer. The same count governs both directions, so one transfer can move bytes out and bring bytes back at the same time.

On the transmit side, incoming bytes are gathered into words of up to four bytes. The earliest byte of a group takes the most significant occupied byte lane. When fewer than four bytes remain, the last group is right-aligned: it fills only the low lanes and the unused upper lanes are zero. On the receive side, each incoming word is split back into bytes using the same lane positions. For the final word, only as many bytes as the transfer still owes are emitted, and the unused upper lanes are dropped. Each direction keeps its own remaining-byte counter and raises its own done flag when that counter reaches zero and nothing is still pending.

Top module: `byte_word_packer`

## Requirements
- R1: A full group of four bytes b0..b3 forms the word {b0,b1,b2,b3}: b0 in bits 31:24 and b3 in bits 7:0.
- R2: A final short group is right-aligned with zero upper bits. Three bytes give {8'h00,b0,b1,b2}, two bytes give {16'h0000,b0,b1}, and one byte gives {24'h0,b0}.
- R3: A transfer of N bytes produces exactly ceil(N/4) transmit words and accepts exactly ceil(N/4) receive words.
- R4: Each receive word is emitted as min(4, remaining) bytes. For a word with g bytes to emit, the first byte comes from bits 8g-1:8g-8 and the last from bits 7:0. Bytes in the lanes above are discarded.
- R5: Each done flag reads 0 after reset and after a start with a nonzero count. A flag rises once its direction has passed all N bytes, the transmit flag only after the final word has been taken. A flag stays high until the next accepted start.
- R6: A start is accepted only while idle_o is 1, meaning both directions have nothing left to do. A start while busy is ignored and does not change the count of the transfer in progress.
- R7: A start with count 0 sets both done flags in the next cycle. It produces no word, requests no byte or word, and leaves idle_o at 1.
- R8: A single start loads the count into both directions. The transmit and receive halves advance independently and can run at the same time.
- R9: While an output valid is high and its ready is low, the valid stays high and the data stays unchanged in the next cycle.
- R10: After reset, idle_o is 1, both done flags are 0, and no valid or ready output is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to load a new byte count |
| count_i | input | CNT_W | Total bytes in the transfer |
| idle_o | output | 1 | Both directions have finished |
| tx_byte_valid_i | input | 1 | Transmit byte offered |
| tx_byte_i | input | 8 | Transmit byte |
| tx_byte_ready_o | output | 1 | Transmit byte accepted |
| tx_word_valid_o | output | 1 | Packed word available |
| tx_word_o | output | 32 | Packed word |
| tx_word_ready_i | input | 1 | Packed word taken |
| tx_done_o | output | 1 | Transmit side has finished |
| rx_word_valid_i | input | 1 | Receive word offered |
| rx_word_i | input | 32 | Receive word |
| rx_word_ready_o | output | 1 | Receive word accepted |
| rx_byte_valid_o | output | 1 | Unpacked byte available |
| rx_byte_o | output | 8 | Unpacked byte |
| rx_byte_ready_i | input | 1 | Unpacked byte taken |
| rx_done_o | output | 1 | Receive side has finished |

## Verification
If the lane-fill state is corrupted, the very next word shows bytes in the wrong lanes or stray nonzero upper bits. A miscounted remaining-byte register shows up by the end of the same transfer, as one word too many or too few, a short final group in the wrong lanes, or a done flag that rises early or never. On the receive side, a wrong group length at word load changes the first byte emitted from that word in the following cycle. A stuck hold flag stops the receive word handshake from the next word onward. The bench sweeps every byte count from 0 to 13 under four backpressure patterns. That covers every short-group length in both directions, and it makes each of these faults visible within one transfer.

// File: rtl/bwp_pkg.sv
package bwp_pkg;
  localparam int unsigned BYTE_W     = 8;
  localparam int unsigned WORD_BYTES = 4;
  localparam int unsigned WORD_W     = BYTE_W * WORD_BYTES;

  // bytes in the next group: min(WORD_BYTES, remaining)
  function automatic logic [2:0] group_len(input logic [31:0] rem);
    return (rem >= 32'(WORD_BYTES)) ? 3'(WORD_BYTES) : rem[2:0];
  endfunction
endpackage

// File: rtl/bwp_pack.sv
module bwp_pack
  import bwp_pkg::*;
#(
  parameter int unsigned CNT_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              byte_valid_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic              byte_ready_o,
  output logic              word_valid_o,
  output logic [WORD_W-1:0] word_o,
  input  logic              word_ready_i,
  output logic              done_o,
  output logic              idle_o
);
  localparam int unsigned ACC_W = WORD_W - BYTE_W;

  logic [CNT_W-1:0]  rem_q;
  logic [ACC_W-1:0]  acc_q;
  logic [1:0]        fill_q;
  logic              wvalid_q;
  logic [WORD_W-1:0] word_q;
  logic              done_q;

  logic byte_fire, word_fire, group_end;

  assign byte_ready_o = (rem_q != '0) && !wvalid_q;
  assign byte_fire    = byte_valid_i && byte_ready_o;
  assign word_fire    = wvalid_q && word_ready_i;
  assign group_end    = (fill_q == 2'(WORD_BYTES - 1)) || (rem_q == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q    <= '0;
      acc_q    <= '0;
      fill_q   <= '0;
      wvalid_q <= 1'b0;
      word_q   <= '0;
      done_q   <= 1'b0;
    end else if (load_i) begin
      rem_q  <= count_i;
      acc_q  <= '0;
      fill_q <= '0;
      done_q <= (count_i == '0);
    end else begin
      if (byte_fire) begin
        rem_q <= rem_q - CNT_W'(1);
        if (group_end) begin
          // shifting into a cleared accumulator right-aligns short groups
          word_q   <= {acc_q, byte_i};
          wvalid_q <= 1'b1;
          acc_q    <= '0;
          fill_q   <= '0;
        end else begin
          acc_q  <= {acc_q[ACC_W-BYTE_W-1:0], byte_i};
          fill_q <= fill_q + 2'd1;
        end
      end
      if (word_fire) begin
        wvalid_q <= 1'b0;
        if (rem_q == '0) done_q <= 1'b1;
      end
    end
  end

  assign word_valid_o = wvalid_q;
  assign word_o       = word_q;
  assign done_o       = done_q;
  assign idle_o       = (rem_q == '0) && !wvalid_q;
endmodule

// File: rtl/bwp_unpack.sv
module bwp_unpack
  import bwp_pkg::*;
#(
  parameter int unsigned CNT_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              word_valid_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              word_ready_o,
  output logic              byte_valid_o,
  output logic [BYTE_W-1:0] byte_o,
  input  logic              byte_ready_i,
  output logic              done_o,
  output logic              idle_o
);
  logic [CNT_W-1:0]  rem_q;
  logic [WORD_W-1:0] sh_q;
  logic [2:0]        left_q;
  logic              hold_q;
  logic              done_q;

  logic       word_fire, byte_fire;
  logic [2:0] glen;
  logic [4:0] lane_shift;

  assign word_ready_o = (rem_q != '0) && !hold_q;
  assign word_fire    = word_valid_i && word_ready_o;
  assign byte_fire    = hold_q && byte_ready_i;
  assign glen         = group_len(32'(rem_q));
  // move the first owed byte up to the top lane
  assign lane_shift   = 5'(WORD_BYTES - 32'(glen)) << 3;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q  <= '0;
      sh_q   <= '0;
      left_q <= '0;
      hold_q <= 1'b0;
      done_q <= 1'b0;
    end else if (load_i) begin
      rem_q  <= count_i;
      done_q <= (count_i == '0);
    end else if (word_fire) begin
      sh_q   <= word_i << lane_shift;
      left_q <= glen;
      hold_q <= 1'b1;
    end else if (byte_fire) begin
      sh_q   <= sh_q << BYTE_W;
      left_q <= left_q - 3'd1;
      rem_q  <= rem_q - CNT_W'(1);
      if (left_q == 3'd1) hold_q <= 1'b0;
      if (rem_q == CNT_W'(1)) done_q <= 1'b1;
    end
  end

  assign byte_valid_o = hold_q;
  assign byte_o       = sh_q[WORD_W-1 -: BYTE_W];
  assign done_o       = done_q;
  assign idle_o       = (rem_q == '0) && !hold_q;
endmodule

// File: rtl/byte_word_packer.sv
module byte_word_packer
  import bwp_pkg::*;
#(
  parameter int unsigned CNT_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  count_i,
  output logic              idle_o,
  input  logic              tx_byte_valid_i,
  input  logic [BYTE_W-1:0] tx_byte_i,
  output logic              tx_byte_ready_o,
  output logic              tx_word_valid_o,
  output logic [WORD_W-1:0] tx_word_o,
  input  logic              tx_word_ready_i,
  output logic              tx_done_o,
  input  logic              rx_word_valid_i,
  input  logic [WORD_W-1:0] rx_word_i,
  output logic              rx_word_ready_o,
  output logic              rx_byte_valid_o,
  output logic [BYTE_W-1:0] rx_byte_o,
  input  logic              rx_byte_ready_i,
  output logic              rx_done_o
);
  logic tx_idle, rx_idle, load;

  assign idle_o = tx_idle && rx_idle;
  assign load   = start_i && idle_o;

  bwp_pack #(.CNT_W(CNT_W)) u_pack (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .load_i       (load),
    .count_i      (count_i),
    .byte_valid_i (tx_byte_valid_i),
    .byte_i       (tx_byte_i),
    .byte_ready_o (tx_byte_ready_o),
    .word_valid_o (tx_word_valid_o),
    .word_o       (tx_word_o),
    .word_ready_i (tx_word_ready_i),
    .done_o       (tx_done_o),
    .idle_o       (tx_idle)
  );

  bwp_unpack #(.CNT_W(CNT_W)) u_unpack (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .load_i       (load),
    .count_i      (count_i),
    .word_valid_i (rx_word_valid_i),
    .word_i       (rx_word_i),
    .word_ready_o (rx_word_ready_o),
    .byte_valid_o (rx_byte_valid_o),
    .byte_o       (rx_byte_o),
    .byte_ready_i (rx_byte_ready_i),
    .done_o       (rx_done_o),
    .idle_o       (rx_idle)
  );
endmodule

// File: rtl/byte_word_packer_chk.sv
module byte_word_packer_chk #(
  parameter int unsigned CNT_W = 12
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic [CNT_W-1:0] count_i,
  input logic             idle_o,
  input logic             tx_byte_valid_i,
  input logic [7:0]       tx_byte_i,
  input logic             tx_byte_ready_o,
  input logic             tx_word_valid_o,
  input logic [31:0]      tx_word_o,
  input logic             tx_word_ready_i,
  input logic             tx_done_o,
  input logic             rx_word_valid_i,
  input logic [31:0]      rx_word_i,
  input logic             rx_word_ready_o,
  input logic             rx_byte_valid_o,
  input logic [7:0]       rx_byte_o,
  input logic             rx_byte_ready_i,
  input logic             rx_done_o
);
  p_word_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_word_valid_o && !tx_word_ready_i |=> tx_word_valid_o && $stable(tx_word_o));

  p_byte_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_byte_valid_o && !rx_byte_ready_i |=> rx_byte_valid_o && $stable(rx_byte_o));

  p_tx_done_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_done_o |-> !tx_word_valid_o && !tx_byte_ready_o);

  p_rx_done_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_done_o |-> !rx_byte_valid_o && !rx_word_ready_o);

  p_tx_done_cause_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_done_o) |-> $past(start_i || (tx_word_valid_o && tx_word_ready_i)));

  p_idle_no_request_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_o |-> !tx_byte_ready_o && !rx_word_ready_o && !tx_word_valid_o && !rx_byte_valid_o);
endmodule

bind byte_word_packer byte_word_packer_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/byte_word_packer_tb_top.sv
module byte_word_packer_tb_top;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned CNT_W      = 12;
  localparam int unsigned MAX_N      = 13;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             start_i = 1'b0;
  logic [CNT_W-1:0] count_i = '0;
  logic             idle_o;
  logic             tx_byte_valid_i = 1'b0;
  logic [7:0]       tx_byte_i = '0;
  logic             tx_byte_ready_o;
  logic             tx_word_valid_o;
  logic [31:0]      tx_word_o;
  logic             tx_word_ready_i = 1'b0;
  logic             tx_done_o;
  logic             rx_word_valid_i = 1'b0;
  logic [31:0]      rx_word_i = '0;
  logic             rx_word_ready_o;
  logic             rx_byte_valid_o;
  logic [7:0]       rx_byte_o;
  logic             rx_byte_ready_i = 1'b0;
  logic             rx_done_o;

  int total = 0;
  int bad   = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  byte_word_packer #(.CNT_W(CNT_W)) dut_i (.*);

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] tx_b(input int n, input int k);
    return 8'((n * 7 + k * 13 + 1) & 255);
  endfunction

  function automatic logic [31:0] rx_w(input int n, input int j);
    return 32'hA1B2C3D4 ^ (32'(n) * 32'h01010101 + 32'(j) * 32'h10203040);
  endfunction

  function automatic int glen(input int n, input int j);
    return (n - 4 * j >= 4) ? 4 : n - 4 * j;
  endfunction

  function automatic logic [31:0] exp_word(input int n, input int j);
    logic [31:0] w = '0;
    for (int i = 0; i < glen(n, j); i++)
      w = (w << 8) | 32'(tx_b(n, 4 * j + i));
    return w;
  endfunction

  function automatic bit pace(input int cyc, input int m);
    return (m == 3) || (((cyc + m) % 3) != 0);
  endfunction

  task automatic tx_feed(input int n, input int m);
    for (int k = 0; k < n; k++) begin
      if (((k + m) % 4) == 3) begin
        tx_byte_valid_i = 1'b0;
        @(negedge clk_i);
      end
      tx_byte_valid_i = 1'b1;
      tx_byte_i = tx_b(n, k);
      while (!tx_byte_ready_o) @(negedge clk_i);
      @(negedge clk_i);
    end
    tx_byte_valid_i = 1'b0;
  endtask

  task automatic tx_sink(input int n, input int m);
    int got = 0;
    int cyc = 0;
    bit pend = 1'b0;
    logic [31:0] held = '0;
    while (got < (n + 3) / 4) begin
      tx_word_ready_i = pace(cyc, m);
      if (pend && tx_word_valid_o) check(tx_word_o == held, "R9 word hold", tx_word_o, held);
      pend = 1'b0;
      if (tx_word_valid_o && tx_word_ready_i) begin
        check(tx_word_o == exp_word(n, got), (glen(n, got) == 4) ? "R1 full word" : "R2 short word",
              tx_word_o, exp_word(n, got));
        got++;
      end else if (tx_word_valid_o) begin
        pend = 1'b1;
        held = tx_word_o;
      end
      @(negedge clk_i);
      cyc++;
    end
    tx_word_ready_i = 1'b0;
  endtask

  task automatic rx_feed(input int n, input int m);
    for (int j = 0; j < (n + 3) / 4; j++) begin
      if (m == 2) begin
        rx_word_valid_i = 1'b0;
        @(negedge clk_i);
      end
      rx_word_valid_i = 1'b1;
      rx_word_i = rx_w(n, j);
      while (!rx_word_ready_o) @(negedge clk_i);
      @(negedge clk_i);
    end
    rx_word_valid_i = 1'b0;
  endtask

  task automatic rx_sink(input int n, input int m);
    int got = 0;
    int cyc = 0;
    bit pend = 1'b0;
    logic [7:0] held = '0;
    logic [7:0] e;
    while (got < n) begin
      rx_byte_ready_i = pace(cyc + 1, m);
      if (pend && rx_byte_valid_o) check(rx_byte_o == held, "R9 byte hold", 32'(rx_byte_o), 32'(held));
      pend = 1'b0;
      if (rx_byte_valid_o && rx_byte_ready_i) begin
        e = 8'(rx_w(n, got / 4) >> (8 * (glen(n, got / 4) - 1 - got % 4)));
        check(rx_byte_o == e, "R4 rx byte", 32'(rx_byte_o), 32'(e));
        got++;
      end else if (rx_byte_valid_o) begin
        pend = 1'b1;
        held = rx_byte_o;
      end
      @(negedge clk_i);
      cyc++;
    end
    rx_byte_ready_i = 1'b0;
  endtask

  task automatic intruder(input int n, input int m);
    if (m == 1 && n >= 5) begin
      repeat (3) @(negedge clk_i);
      check(idle_o == 1'b0, "R6 busy before second start", 32'(idle_o), 32'd0);
      start_i = 1'b1;
      count_i = CNT_W'(n + 4);
      @(negedge clk_i);
      start_i = 1'b0;
    end
  endtask

  task automatic run_case(input int n, input int m);
    @(negedge clk_i);
    start_i = 1'b1;
    count_i = CNT_W'(n);
    @(negedge clk_i);
    start_i = 1'b0;
    if (n == 0) begin
      check(tx_done_o && rx_done_o, "R7 zero count done", {tx_done_o, rx_done_o}, 2'b11);
      check(!tx_byte_ready_o && !rx_word_ready_o && !tx_word_valid_o && idle_o,
            "R7 zero count quiet", {idle_o, tx_byte_ready_o, rx_word_ready_o, tx_word_valid_o}, 4'b1000);
    end else begin
      check(!tx_done_o && !rx_done_o, "R5 done cleared", {tx_done_o, rx_done_o}, 2'b00);
      check(tx_byte_ready_o && rx_word_ready_o && !idle_o, "R8 both sides loaded",
            {tx_byte_ready_o, rx_word_ready_o, idle_o}, 3'b110);
      fork
        tx_feed(n, m);
        tx_sink(n, m);
        rx_feed(n, m);
        rx_sink(n, m);
        intruder(n, m);
      join
      for (int w = 0; w < 3; w++) begin
        check(!tx_word_valid_o && !rx_word_ready_o, "R3 no extra words",
              {tx_word_valid_o, rx_word_ready_o}, 2'b00);
        @(negedge clk_i);
      end
      check(tx_done_o && rx_done_o, "R5 done raised", {tx_done_o, rx_done_o}, 2'b11);
      check(idle_o, "R6 busy start ignored", 32'(idle_o), 32'd1);
    end
  endtask

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 100000) begin
      total++;
      bad++;
      $display("FAIL watchdog act=%0d exp=done", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check(idle_o && !tx_done_o && !rx_done_o && !tx_word_valid_o && !rx_byte_valid_o
          && !tx_byte_ready_o && !rx_word_ready_o, "R10 reset state",
          {idle_o, tx_done_o, rx_done_o, tx_word_valid_o, rx_byte_valid_o, tx_byte_ready_o, rx_word_ready_o},
          7'b1000000);
    rst_ni = 1'b1;
    for (int m = 0; m < 4; m++)
      for (int n = 0; n <= MAX_N; n++)
        run_case(n, m);
    // done persists until the next start
    repeat (5) @(negedge clk_i);
    check(tx_done_o && rx_done_o, "R5 done sticky", {tx_done_o, rx_done_o}, 2'b11);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule